// File: doc/BRIEF.md
# Programmable Asymmetric Frequency Divider

This block divides a slow external pulse train by a programmable integer and sets the duty cycle of the result. The external signal is asynchronous to the system clock. It is first brought into the clock domain through a chain of synchronizing flops. Each complete period of the signal, meaning high and then low again, is then detected as one count.

A single cycle counter measures the current phase of the output. The output stays low for `low_len` counted periods and high for `high_len` counted periods. The total division ratio is therefore the sum of the two lengths. Odd ratios and strongly unequal mark-space ratios come out of the same counter. For example, 5 and 6 give divide-by-11, and 2 and 28 give divide-by-30 at a 1:14 ratio.

All pins are plain control and status signals, with no streaming handshake. The phase lengths are sampled only at reset and at each phase boundary. Software can therefore rewrite them at any time without producing a truncated phase.

Top module: `ratio_divider`

## Requirements
- R1: While `rst` is high at a clock edge, `div_out` goes to 0 and the cycle counter goes to 0. The low phase becomes active, with its length taken from `low_len` as sampled at that edge.
- R2: One count is taken for each full period of `sig_in`, seen as a high level followed by a low level after synchronization. `div_out` can change no earlier than the third rising clock edge after `sig_in` falls. Holding each level for two or more clock periods is enough for it to be seen.
- R3: The counted periods are compared with the active phase length by exact equality. On a match, `div_out` inverts and the counter restarts from zero in the same cycle. The period that completes a phase is not counted in the next phase.
- R4: After its first toggle, `div_out` repeats a pattern of `high_len` periods high followed by `low_len` periods low. One output cycle thus spans `high_len + low_len` input periods, whether that sum is odd or even.
- R5: A programmed phase length of 0 acts as a length of 1.
- R6: A phase length is latched when its phase begins. A phase begins at reset for the low phase, and at each toggle for the phase being entered. Values written during a phase do not affect that phase.
- R7: While `enable` is low, the counter and `div_out` hold their values. Input periods that complete during that time are not counted.
- R8: Each phase length can be as large as 32767, so the total divisor can reach 65534. For example, with `low_len` = 32767, `div_out` stays low through 32766 periods and rises on the 32767th.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run well faster than `sig_in` |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | 1 | Asynchronous pulse train to be divided |
| high_len | input | 15 | Number of input periods for the high phase (0 acts as 1) |
| low_len | input | 15 | Number of input periods for the low phase (0 acts as 1) |
| enable | input | 1 | High to count; low freezes counter and output |
| div_out | output | 1 | Divided output |

## Verification
On every cycle, the assertions check the following:
- the output changes only on a counted edge, and the counter is zero whenever it does;
- the counter stays below the latched phase length, and that length is never zero;
- a detected fall lasts a single clock;
- nothing moves while the block is disabled.

Some behaviour needs whole pulse trains, so only the bench scenarios can show it:
- the overall division ratio and duty pattern for even, odd and lopsided settings;
- reprogramming that takes effect only at the next boundary;
- the treatment of zero as one;
- the full 32767-period phase.

// File: rtl/ratio_divider_pkg.sv
package ratio_divider_pkg;

  // Which output phase the counter is currently timing.
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

endpackage

// File: rtl/sig_fall_detect.sv
module sig_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic fall
);

  localparam int MSB = STAGES - 1;

  logic [MSB:0] chain_q;
  logic         prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= async_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[MSB-1:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[MSB];
  end

  // A completed period: the synchronized level was high and is now low.
  assign fall = prev_q & ~chain_q[MSB];

  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall); // R2

endmodule

// File: rtl/phase_counter.sv
module phase_counter
  import ratio_divider_pkg::*;
#(
  parameter int LEN_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [LEN_W-1:0] hi_len,
  input  logic [LEN_W-1:0] lo_len,
  output logic             out_level
);

  localparam int CW = LEN_W + 1;

  phase_e           phase_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] act_len_q;
  logic [CW-1:0]    cnt_inc;
  logic             hit;
  logic [LEN_W-1:0] hi_eff;
  logic [LEN_W-1:0] lo_eff;

  // A length of zero is treated as one.
  assign hi_eff  = (hi_len == '0) ? LEN_W'(1) : hi_len;
  assign lo_eff  = (lo_len == '0) ? LEN_W'(1) : lo_len;
  assign cnt_inc = {1'b0, cnt_q} + CW'(1);
  assign hit     = (cnt_inc == {1'b0, act_len_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_LOW;
      cnt_q     <= '0;
      act_len_q <= lo_eff;
    end else if (tick) begin
      if (hit) begin
        cnt_q <= '0;
        if (phase_q == PH_LOW) begin
          phase_q   <= PH_HIGH;
          act_len_q <= hi_eff;
        end else begin
          phase_q   <= PH_LOW;
          act_len_q <= lo_eff;
        end
      end else begin
        cnt_q <= cnt_inc[LEN_W-1:0];
      end
    end
  end

  assign out_level = (phase_q == PH_HIGH);

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (phase_q == PH_LOW && cnt_q == '0)); // R1
  AST_TOGGLE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase_q) |-> $past(tick)); // R3
  AST_RESTART_ON_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase_q) |-> cnt_q == '0); // R3
  AST_COUNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt_q < act_len_q); // R8
  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    act_len_q != '0); // R5
  AST_LEN_HELD_IN_PHASE: assert property (@(posedge clk) disable iff (rst)
    $stable(phase_q) |-> $stable(act_len_q)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q) && $stable(phase_q)); // R7

endmodule

// File: rtl/ratio_divider.sv
module ratio_divider #(
  parameter int LEN_W       = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig_in,
  input  logic [LEN_W-1:0] high_len,
  input  logic [LEN_W-1:0] low_len,
  input  logic             enable,
  output logic             div_out
);

  logic fall;
  logic tick;

  sig_fall_detect #(
    .STAGES(SYNC_STAGES)
  ) u_detect (
    .clk      (clk),
    .rst      (rst),
    .async_in (sig_in),
    .fall     (fall)
  );

  // Edges seen while disabled are dropped, not deferred.
  assign tick = fall & enable;

  phase_counter #(
    .LEN_W(LEN_W)
  ) u_count (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .hi_len    (high_len),
    .lo_len    (low_len),
    .out_level (div_out)
  );

  AST_FROZEN_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(div_out)); // R7

endmodule

// File: tb/ratio_divider_test.sv
module ratio_divider_test;

  localparam int LEN_W = 15;
  localparam int NVEC  = 7;
  // Each entry: {high_len, low_len}
  localparam logic [2*LEN_W-1:0] VECS [0:NVEC-1] = '{
    {15'd5,  15'd5},
    {15'd5,  15'd6},
    {15'd10, 15'd20},
    {15'd2,  15'd28},
    {15'd1,  15'd1},
    {15'd0,  15'd3},
    {15'd3,  15'd0}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             sig_in = 1'b0;
  logic [LEN_W-1:0] high_len = '0;
  logic [LEN_W-1:0] low_len = '0;
  logic             enable = 1'b1;
  logic             div_out;

  int  checks = 0;
  int  errors = 0;
  int  e_cnt = 0;
  int  e_len = 1;
  bit  e_out = 1'b0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  ratio_divider #(.LEN_W(LEN_W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .sig_in(sig_in), .high_len(high_len),
    .low_len(low_len), .enable(enable), .div_out(div_out)
  );

  function automatic int clamp1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic check(input bit got, input bit exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: div_out=%0b expected=%0b", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    e_cnt = 0;
    e_out = 1'b0;
    e_len = clamp1(int'(low_len));
  endtask

  // One full input period: high for 2 clocks, low for lo_hold clocks.
  task automatic pulse(input int lo_hold);
    @(negedge clk);
    sig_in = 1'b1;
    repeat (2) @(negedge clk);
    sig_in = 1'b0;
    repeat (lo_hold) @(negedge clk);
  endtask

  task automatic model_step();
    if (!enable) return;
    e_cnt++;
    if (e_cnt == e_len) begin
      e_cnt = 0;
      e_out = !e_out;
      e_len = e_out ? clamp1(int'(high_len)) : clamp1(int'(low_len));
    end
  endtask

  // Pulse, let the synchronizer and counter settle, then compare.
  task automatic pulse_check(input string req);
    pulse(4);
    model_step();
    check(div_out, e_out, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: div_out=%0b expected=finish", div_out);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    high_len = 15'd4;
    low_len  = 15'd4;
    do_reset();
    repeat (2) @(negedge clk);
    check(div_out, 1'b0, "R1 reset output low");

    // Table walk: R3/R4 patterns, R5 zero lengths
    for (int v = 0; v < NVEC; v++) begin
      high_len = VECS[v][2*LEN_W-1:LEN_W];
      low_len  = VECS[v][LEN_W-1:0];
      do_reset();
      for (int p = 0; p < 2 * (clamp1(int'(high_len)) + clamp1(int'(low_len))) + 3; p++)
        pulse_check((VECS[v][2*LEN_W-1:LEN_W] == '0 || VECS[v][LEN_W-1:0] == '0)
                    ? "R5 zero length" : "R4 ratio pattern");
    end

    // R2: no count until the fall is synchronized; exact cycle timing
    high_len = 15'd1;
    low_len  = 15'd1;
    do_reset();
    @(negedge clk); sig_in = 1'b1;
    repeat (3) @(negedge clk);
    check(div_out, 1'b0, "R2 high level alone is not a count");
    sig_in = 1'b0;
    repeat (2) @(negedge clk);
    check(div_out, 1'b0, "R2 two edges after fall");
    @(negedge clk);
    check(div_out, 1'b1, "R2 third edge after fall");
    e_out = 1'b1; e_cnt = 0; e_len = 1;

    // R6: lengths changed mid-phase take effect at the next boundary
    high_len = 15'd2;
    low_len  = 15'd2;
    do_reset();
    pulse_check("R6 before change");
    high_len = 15'd4;
    low_len  = 15'd5;
    pulse_check("R6 current low phase keeps old length");
    for (int p = 0; p < 12; p++) pulse_check("R6 new lengths after boundary");

    // R7: enable low freezes and drops periods
    high_len = 15'd3;
    low_len  = 15'd3;
    do_reset();
    pulse_check("R7 pre-disable");
    pulse_check("R7 pre-disable");
    @(negedge clk); enable = 1'b0;
    for (int p = 0; p < 5; p++) pulse(4);
    check(div_out, 1'b0, "R7 held while disabled");
    @(negedge clk); enable = 1'b1;
    pulse_check("R7 resumes count where it stopped");
    check(div_out, 1'b1, "R7 toggle on third counted period");
    for (int p = 0; p < 2; p++) pulse_check("R7 high phase continues");
    @(negedge clk); enable = 1'b0;
    for (int p = 0; p < 3; p++) pulse(4);
    check(div_out, 1'b1, "R7 held high while disabled");
    @(negedge clk); enable = 1'b1;
    pulse_check("R3 exact match after resume");

    // R8: maximum phase length
    high_len = 15'd1;
    low_len  = 15'd32767;
    do_reset();
    for (int p = 0; p < 32766; p++) pulse(2);
    repeat (3) @(negedge clk);
    check(div_out, 1'b0, "R8 still low after 32766 periods");
    pulse(4);
    check(div_out, 1'b1, "R8 high after 32767 periods");
    pulse(4);
    check(div_out, 1'b0, "R3 one-period high phase");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule